// File: doc/BRIEF.md
# NAND Parameter Record Scanner

The block watches a byte stream that carries one data page read from the parameter area of a serial NAND device. The page holds several identical 256-byte copies of the parameter record, placed back to back from offset 0 up to the configured page length. The block runs a CRC-16 over each copy and compares it with the check value stored at the end of that copy. The first copy whose check matches is taken as the record of reference. Later copies are ignored.

From the accepted copy the block keeps these fields: data bytes per page, spare bytes per page, pages per block, blocks per logical unit and the number of logical units. It derives the erase-block size and the total device size from them. It compares page, block and total size against three configured values and raises one warning per mismatch. A warning does not withdraw the result. If no copy in the page carries a correct check value, the block ends the scan with a no-record flag.

A host controller streams the page in with `in_sop` on its first byte. It then waits for `done`. After that it reads `valid`, the geometry outputs and the warning flags.

Top module: `nand_param_scan`

## Requirements
- R1: After reset, `done`, `valid`, `no_record`, `sig_ok` and all three warnings are low, and every geometry output is zero.
- R2: A copy's check is CRC-16 with polynomial 0x8005, processed MSB-first, no reflection, no final XOR, starting from 0x4F4E. It covers copy bytes 0 to 253. It is compared with the little-endian value at copy bytes 254 (low byte) and 255 (high byte).
- R3: The first copy in page order whose check matches supplies the result. Copies after it, whether good or bad, do not change any output.
- R4: If no copy up to the page length matches, `done` and `no_record` rise after the last byte of the page, and `valid` stays low.
- R5: Field positions within a copy, all little-endian: data bytes per page occupies bytes 80..83, spare bytes per page 84..85, pages per block 92..95, blocks per unit 96..99, and unit count byte 100.
- R6: `block_bytes` equals data bytes per page times pages per block. `total_bytes` equals `block_bytes` times blocks per unit times unit count. Both are 64-bit and exact for products below 2^64.
- R7: `warn_page`, `warn_block` and `warn_total` are each high exactly when `valid` is high and the matching configured input differs. `valid` does not depend on them.
- R8: `done` and `valid` stay low while a matching copy is being received. They rise in the cycle after its byte 255 is accepted.
- R9: A byte with `in_sop` and `in_valid` both high is taken as page offset 0. It restarts the scan and clears `done`, `valid` and `no_record` in the next cycle.
- R10: Cycles with `in_valid` low have no effect. Once `done` is high, bytes without `in_sop` leave every output unchanged.
- R11: `sig_ok` is high when `valid` is high and the accepted copy begins with bytes 0x4F, 0x4E, 0x46, 0x49. A wrong signature lowers only `sig_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | Marks the first byte of a page |
| in_byte | input | 8 | Page data byte |
| cfg_page_bytes | input | 32 | Expected data bytes per page |
| cfg_block_bytes | input | 64 | Expected erase-block size |
| cfg_total_bytes | input | 64 | Expected device size |
| done | output | 1 | Scan finished |
| valid | output | 1 | A copy with a correct check was found |
| no_record | output | 1 | Scan finished with no good copy |
| sig_ok | output | 1 | Accepted copy starts with the expected signature |
| data_bytes | output | 32 | Data bytes per page |
| spare_bytes | output | 16 | Spare bytes per page |
| pages_per_block | output | 32 | Pages per erase block |
| blocks_per_unit | output | 32 | Blocks per logical unit |
| unit_count | output | 8 | Number of logical units |
| block_bytes | output | 64 | Derived erase-block size |
| total_bytes | output | 64 | Derived device size |
| warn_page | output | 1 | Page size differs from configuration |
| warn_block | output | 1 | Block size differs from configuration |
| warn_total | output | 1 | Total size differs from configuration |

## Verification
The bench builds the block with a 1024-byte page, so each page carries four record copies. With four copies, a good first copy, a good middle copy, a good last copy and a page with no good copy can all be reached in a short run. It can also place a second good copy with different geometry after the first one, to show that the first wins. Field values large enough to push the derived block size past 32 bits test the width of the products.

// File: rtl/nand_param_scan.sv
module nand_param_scan #(
  parameter int PAGE_BYTES = 2048,
  parameter logic [15:0] CRC_SEED = 16'h4F4E,
  parameter logic [15:0] CRC_POLY = 16'h8005
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic [7:0]  in_byte,
  input  logic [31:0] cfg_page_bytes,
  input  logic [63:0] cfg_block_bytes,
  input  logic [63:0] cfg_total_bytes,
  output logic        done,
  output logic        valid,
  output logic        no_record,
  output logic        sig_ok,
  output logic [31:0] data_bytes,
  output logic [15:0] spare_bytes,
  output logic [31:0] pages_per_block,
  output logic [31:0] blocks_per_unit,
  output logic [7:0]  unit_count,
  output logic [63:0] block_bytes,
  output logic [63:0] total_bytes,
  output logic        warn_page,
  output logic        warn_block,
  output logic        warn_total
);

  localparam int OW = $clog2(PAGE_BYTES);

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ b[i]) ? CRC_POLY : 16'h0000);
    return r;
  endfunction

  logic [OW-1:0] off;
  logic [15:0]   crc;
  logic [7:0]    chk_lo;
  logic          sig_q;
  logic          done_q, valid_q, norec_q;
  logic [31:0]   data_q, ppb_q, bpu_q;
  logic [15:0]   spare_q;
  logic [7:0]    luns_q;

  wire           sop    = in_valid && in_sop;
  wire           accept = in_valid && (in_sop || !done_q);
  wire [OW-1:0]  pos    = in_sop ? '0 : off;
  wire [7:0]     ci     = pos[7:0];
  wire           last   = (pos == OW'(PAGE_BYTES - 1));
  wire [15:0]    crc_nx = crc_step((ci == 8'd0) ? CRC_SEED : crc, in_byte);
  wire           match  = (crc == {in_byte, chk_lo});

  logic [7:0] sig_exp;
  always_comb begin
    case (ci[1:0])
      2'd0:    sig_exp = 8'h4F;
      2'd1:    sig_exp = 8'h4E;
      2'd2:    sig_exp = 8'h46;
      default: sig_exp = 8'h49;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off <= '0; crc <= '0; chk_lo <= '0; sig_q <= 1'b0;
      done_q <= 1'b0; valid_q <= 1'b0; norec_q <= 1'b0;
      data_q <= '0; spare_q <= '0; ppb_q <= '0; bpu_q <= '0; luns_q <= '0;
    end else if (accept) begin
      off <= pos + 1'b1;
      if (sop) begin
        done_q <= 1'b0; valid_q <= 1'b0; norec_q <= 1'b0;
      end
      if (ci < 8'd254) crc <= crc_nx;
      if (ci == 8'd0) begin
        data_q <= '0; spare_q <= '0; ppb_q <= '0; bpu_q <= '0; luns_q <= '0;
        sig_q <= (in_byte == sig_exp);
      end else if (ci < 8'd4) begin
        sig_q <= sig_q && (in_byte == sig_exp);
      end
      if (ci >= 8'd80 && ci <= 8'd83) data_q[{ci[1:0], 3'b000} +: 8] <= in_byte;
      if (ci >= 8'd84 && ci <= 8'd85) spare_q[{ci[0], 3'b000} +: 8] <= in_byte;
      if (ci >= 8'd92 && ci <= 8'd95) ppb_q[{ci[1:0], 3'b000} +: 8] <= in_byte;
      if (ci >= 8'd96 && ci <= 8'd99) bpu_q[{ci[1:0], 3'b000} +: 8] <= in_byte;
      if (ci == 8'd100) luns_q <= in_byte;
      if (ci == 8'd254) chk_lo <= in_byte;
      if (ci == 8'd255) begin
        if (match) begin
          done_q <= 1'b1; valid_q <= 1'b1;
        end else if (last) begin
          done_q <= 1'b1; norec_q <= 1'b1;
        end
      end
    end
  end

  assign done            = done_q;
  assign valid           = valid_q;
  assign no_record       = norec_q;
  assign sig_ok          = valid_q && sig_q;
  assign data_bytes      = data_q;
  assign spare_bytes     = spare_q;
  assign pages_per_block = ppb_q;
  assign blocks_per_unit = bpu_q;
  assign unit_count      = luns_q;
  assign block_bytes     = {32'd0, data_q} * {32'd0, ppb_q};
  assign total_bytes     = block_bytes * {32'd0, bpu_q} * {56'd0, luns_q};
  assign warn_page       = valid_q && (data_q != cfg_page_bytes);
  assign warn_block      = valid_q && (block_bytes != cfg_block_bytes);
  assign warn_total      = valid_q && (total_bytes != cfg_total_bytes);

  // R3
  valid_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> done);
  // R4
  norec_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_record |-> (done && !valid));
  // R9
  sop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |=> (!done && !valid && !no_record));
  // R10
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(in_valid && in_sop)) |=> (done && $stable(data_bytes) && $stable(total_bytes) && $stable(valid)));
  // R7
  warn_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_page || warn_block || warn_total) |-> valid);

endmodule

// File: tb/nand_param_scan_tb_top.sv
module nand_param_scan_tb_top;
  localparam int PB = 1024;
  localparam int NC = PB / 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [31:0] cfg_page_bytes = '0;
  logic [63:0] cfg_block_bytes = '0, cfg_total_bytes = '0;
  logic done, valid, no_record, sig_ok, warn_page, warn_block, warn_total;
  logic [31:0] data_bytes, pages_per_block, blocks_per_unit;
  logic [15:0] spare_bytes;
  logic [7:0] unit_count;
  logic [63:0] block_bytes, total_bytes;

  always #2 clk = ~clk;

  nand_param_scan #(.PAGE_BYTES(PB)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_byte(in_byte),
    .cfg_page_bytes(cfg_page_bytes), .cfg_block_bytes(cfg_block_bytes),
    .cfg_total_bytes(cfg_total_bytes), .done(done), .valid(valid), .no_record(no_record),
    .sig_ok(sig_ok), .data_bytes(data_bytes), .spare_bytes(spare_bytes),
    .pages_per_block(pages_per_block), .blocks_per_unit(blocks_per_unit),
    .unit_count(unit_count), .block_bytes(block_bytes), .total_bytes(total_bytes),
    .warn_page(warn_page), .warn_block(warn_block), .warn_total(warn_total));

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] pg [0:PB-1];

  // {good copy (4 = none), later duplicate good, bad signature, data, pages/blk, blks/unit, units, cfg mismatch mask}
  localparam logic [111:0] VEC [6] = '{
    {3'd0, 1'b0, 1'b0, 32'd2048,    32'd64,    32'd1024,  8'd1, 3'b000},
    {3'd2, 1'b1, 1'b0, 32'd4096,    32'd64,    32'd2048,  8'd2, 3'b010},
    {3'd3, 1'b0, 1'b0, 32'd512,     32'd32,    32'd4096,  8'd1, 3'b101},
    {3'd4, 1'b0, 1'b0, 32'd2048,    32'd64,    32'd1024,  8'd1, 3'b000},
    {3'd1, 1'b0, 1'b1, 32'h10000,   32'h10000, 32'h100,   8'd4, 3'b111},
    {3'd0, 1'b1, 1'b0, 32'd8192,    32'd128,   32'd512,   8'd3, 3'b000}
  };

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h8005;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic build(input int good, input bit dup, input bit badsig,
                       input logic [31:0] d, input logic [31:0] p,
                       input logic [31:0] b, input logic [7:0] l);
    for (int c = 0; c < NC; c++) begin
      logic [31:0] dd, pp, bb;
      logic [7:0] ll;
      logic [15:0] cr;
      bit ok;
      int base;
      base = c * 256;
      ok = (c == good) || (dup && c > good && good < NC);
      dd = (c == good) ? d : d + 32'(c) + 1;
      pp = (c == good) ? p : p + 32'(c) + 3;
      bb = (c == good) ? b : b + 32'(c) + 5;
      ll = (c == good) ? l : l + 8'(c) + 1;
      for (int i = 0; i < 256; i++) pg[base+i] = 8'(i * 29 + c * 7 + 17);
      pg[base+0] = 8'h4F; pg[base+1] = 8'h4E; pg[base+2] = 8'h46;
      pg[base+3] = (badsig && c == good) ? 8'h58 : 8'h49;
      for (int k = 0; k < 4; k++) begin
        pg[base+80+k] = dd[8*k +: 8];
        pg[base+92+k] = pp[8*k +: 8];
        pg[base+96+k] = bb[8*k +: 8];
      end
      pg[base+84] = 8'(c + 8'h40); pg[base+85] = 8'h02;
      pg[base+100] = ll;
      cr = 16'h4F4E;
      for (int i = 0; i < 254; i++) cr = ref_crc(cr, pg[base+i]);
      if (!ok) cr = cr ^ 16'h0100;
      pg[base+254] = cr[7:0];
      pg[base+255] = cr[15:8];
    end
  endtask

  task automatic send(input int lo, input int hi, input bit with_sop, input bit gaps);
    for (int i = lo; i <= hi; i++) begin
      if (gaps && (i % 37 == 5)) begin
        @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; in_byte = 8'hA5;
      end
      @(negedge clk);
      in_valid = 1'b1; in_sop = with_sop && (i == lo); in_byte = pg[i];
    end
    @(negedge clk); in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic run_vec(input int k, input bit gaps);
    logic [111:0] v;
    int good;
    logic [2:0] m;
    logic [63:0] eb, et;
    bit ev;
    v = VEC[k];
    good = int'(v[111:109]); m = v[2:0];
    build(good, v[108], v[107], v[106:75], v[74:43], v[42:11], v[10:3]);
    eb = 64'(v[106:75]) * 64'(v[74:43]);
    et = eb * 64'(v[42:11]) * 64'(v[10:3]);
    cfg_page_bytes  = v[106:75] ^ {31'd0, m[0]};
    cfg_block_bytes = eb ^ {63'd0, m[1]};
    cfg_total_bytes = et ^ {63'd0, m[2]};
    send(0, PB - 1, 1'b1, gaps);
    ev = (good < NC);
    chk("R3 done", 64'(done), 64'd1);
    chk("R3 valid", 64'(valid), 64'(ev));
    chk("R4 no_record", 64'(no_record), 64'(!ev));
    if (ev) begin
      chk("R5 data_bytes", 64'(data_bytes), 64'(v[106:75]));
      chk("R5 spare_bytes", 64'(spare_bytes), 64'({8'h02, 8'(good + 8'h40)}));
      chk("R5 pages_per_block", 64'(pages_per_block), 64'(v[74:43]));
      chk("R5 blocks_per_unit", 64'(blocks_per_unit), 64'(v[42:11]));
      chk("R5 unit_count", 64'(unit_count), 64'(v[10:3]));
      chk("R6 block_bytes", block_bytes, eb);
      chk("R6 total_bytes", total_bytes, et);
      chk("R11 sig_ok", 64'(sig_ok), 64'(!v[107]));
    end
    chk("R7 warn_page", 64'(warn_page), 64'(ev && m[0]));
    chk("R7 warn_block", 64'(warn_block), 64'(ev && m[1]));
    chk("R7 warn_total", 64'(warn_total), 64'(ev && m[2]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 valid", 64'(valid), 64'd0);
    chk("R1 no_record", 64'(no_record), 64'd0);
    chk("R1 warn", 64'({warn_page, warn_block, warn_total, sig_ok}), 64'd0);
    chk("R1 data_bytes", 64'(data_bytes), 64'd0);
    chk("R1 total_bytes", total_bytes, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R10: vector table, gaps on odd entries
    for (int k = 0; k < 6; k++) run_vec(k, k[0]);

    // R10: bytes after done without sop are ignored
    run_vec(0, 1'b0);
    for (int i = 0; i < 20; i++) pg[i] = 8'(8'hC3 + i);
    send(0, 19, 1'b0, 1'b0);
    chk("R10 done held", 64'(done), 64'd1);
    chk("R10 data held", 64'(data_bytes), 64'd2048);
    chk("R10 total held", total_bytes, 64'd134217728);

    // R9: sop clears done on the next cycle
    build(0, 1'b0, 1'b0, 32'd2048, 32'd64, 32'd1024, 8'd1);
    send(0, 0, 1'b1, 1'b0);
    chk("R9 done cleared", 64'(done), 64'd0);
    chk("R9 valid cleared", 64'(valid), 64'd0);

    // R8: no done before byte 255 of the matching copy
    send(1, 254, 1'b0, 1'b0);
    chk("R8 done early", 64'(done), 64'd0);
    send(255, 255, 1'b0, 1'b0);
    chk("R8 done", 64'(done), 64'd1);
    chk("R8 valid", 64'(valid), 64'd1);

    // R9: restart mid-page, then a different full page
    build(3, 1'b0, 1'b0, 32'd2048, 32'd64, 32'd1024, 8'd1);
    send(0, 299, 1'b1, 1'b0);
    build(1, 1'b0, 1'b0, 32'd4096, 32'd128, 32'd256, 8'd2);
    send(0, PB - 1, 1'b1, 1'b0);
    chk("R9 restart valid", 64'(valid), 64'd1);
    chk("R9 restart data", 64'(data_bytes), 64'd4096);
    chk("R9 restart units", 64'(unit_count), 64'd2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule